// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small byte FIFO placed between a memory bus interface and an instruction decoder. It asks the bus side for 16-bit words of code and keeps the bytes that come back. The decoder takes those bytes one at a time, in address order. Fetching works ahead of decoding. The queue asks for a new word whenever two byte slots are free and no earlier word is still on its way. When the queue is empty, a returning byte reaches the decoder in the same cycle that it arrives.

After a taken branch or any other control transfer, the decoder side pulses `flush` and drives the new code address. The stored bytes are then thrown away. A word that is still in flight is dropped when it returns. Fetching starts again from the new address. If that address is odd, the first word delivers only its upper byte. After that, fetches continue on even addresses.

Both data paths use valid/ready handshakes.
- On the fetch request side, `fetch_valid` together with `fetch_addr` stays unchanged until `fetch_ready` accepts it. A flush is the only exception: it may withdraw the request.
- The fetch response has no ready signal. The queue reserves room before it issues a request, so it can always accept a `resp_valid`. A response is legal only for an accepted request.
- On the consumer side, `byte_data` stays unchanged while `byte_valid` is high and `byte_ready` is low.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most DEPTH (6) bytes and never overflows. When it is full and the consumer stalls, `byte_valid` stays high and `fetch_valid` stays low.
- R2: `fetch_valid` is high exactly when all of these hold: at least two byte slots are free, no accepted request is awaiting its response, and `flush` is low. At most one request is outstanding at a time.
- R3: While `fetch_valid` is high and `fetch_ready` is low, the request and its `fetch_addr` stay unchanged in the following cycle, unless `flush` is high in that cycle.
- R4: Bytes leave in first-in first-out order, one per `byte_valid`&`byte_ready` cycle. A word fetched at even address A supplies byte A from `resp_data[7:0]` first, then byte A+1 from `resp_data[15:8]`.
- R5: When the queue is empty and a kept response arrives, `byte_valid` is high in that same cycle and `byte_data` shows the first byte of the response.
- R6: While `byte_valid` is high and `byte_ready` is low, `byte_valid` and `byte_data` hold in the next cycle unless a flush occurs.
- R7: A write and a read in the same cycle are both performed. The occupancy changes by the bytes written minus the one byte read.
- R8: During a `flush` cycle, `byte_valid` and `fetch_valid` are low. In the next cycle the queue is empty and the next request uses `fetch_addr` = `flush_addr`.
- R9: A request at an odd address yields one byte, `resp_data[15:8]`. The next request goes to that odd address plus one. Each request at an even address advances the fetch address by 2.
- R10: A response to a request that was accepted before a flush never enters the queue. This also holds when the response arrives in the flush cycle itself.
- R11: After reset the queue is empty, `byte_valid` is low, and `fetch_valid` is high with `fetch_addr` = RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that discards the contents and restarts fetching |
| flush_addr | input | AW | Restart address, sampled with `flush` |
| fetch_valid | output | 1 | Word fetch request |
| fetch_ready | input | 1 | Bus side accepts the request |
| fetch_addr | output | AW | Address of the requested code (may be odd right after a restart) |
| resp_valid | input | 1 | Returned word is present |
| resp_data | input | 16 | Returned word, lower address in bits 7:0 |
| byte_valid | output | 1 | A code byte is offered to the decoder |
| byte_ready | input | 1 | Decoder takes the offered byte |
| byte_data | output | 8 | Offered code byte |

## Verification
Some properties are checked on every cycle by the in-RTL assertions:
- occupancy never goes above the depth or past the free room;
- a stalled request or a stalled byte holds steady;
- only one fetch is outstanding at a time;
- a flush empties the queue and reloads the fetch address;
- after an accepted request the next fetch address is even;
- a read and a single-byte write in the same cycle leave the level unchanged.

Other behaviour can only be shown by the bench's scenarios, because it depends on the whole byte stream:
- that the bytes come out in address order across stalls;
- that a response arriving into an empty queue bypasses storage in the same cycle;
- that an odd restart yields exactly one byte;
- that a response still in flight at a flush never reaches the decoder.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // Bytes handed from a returned word to the store, in address order
  typedef struct packed {
    logic [1:0] n;   // number of valid bytes: 0, 1 or 2
    byte_t      b0;  // first byte (lower address)
    byte_t      b1;  // second byte
  } split_t;
endpackage

// File: rtl/pfq_word_split.sv
`timescale 1ns/1ps
module pfq_word_split
  import pfq_pkg::*;
(
  input  logic   keep,
  input  logic   odd,
  input  word_t  word,
  output split_t sp
);
  byte_t lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sp = '0;
    if (keep) begin
      if (odd) begin
        sp.n  = 2'd1;
        sp.b0 = lane[1];
      end else begin
        sp.n  = 2'd2;
        sp.b0 = lane[0];
        sp.b1 = lane[1];
      end
    end
  end
endmodule

// File: rtl/pfq_fetch_ctrl.sv
`timescale 1ns/1ps
module pfq_fetch_ctrl #(
  parameter int unsigned    AW         = 20,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          space_ok,
  input  logic          fetch_ready,
  input  logic          resp_valid,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          keep,
  output logic          keep_odd
);
  logic [AW-1:0] ptr;
  logic          pending;
  logic          stale;
  logic          pend_odd;
  logic [AW-1:0] ptr_next_even;

  assign ptr_next_even = {ptr[AW-1:1] + 1'b1, 1'b0};
  assign fetch_valid   = space_ok && !pending && !flush;
  assign fetch_addr    = ptr;
  assign keep          = resp_valid && pending && !stale && !flush;
  assign keep_odd      = pend_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= RESET_ADDR;
      pending  <= 1'b0;
      stale    <= 1'b0;
      pend_odd <= 1'b0;
    end else begin
      if (resp_valid && pending) begin
        pending <= 1'b0;
        stale   <= 1'b0;
      end
      if (flush) begin
        ptr <= flush_addr;
        if (pending && !resp_valid) stale <= 1'b1;
      end else if (fetch_valid && fetch_ready) begin
        pending  <= 1'b1;
        stale    <= 1'b0;
        pend_odd <= ptr[0];
        ptr      <= ptr_next_even;
      end
    end
  end

  // R3: a stalled request keeps its address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready && !flush |=> flush || (fetch_valid && $stable(fetch_addr)));
  // R2: never a second request while one is in flight
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> !fetch_valid);
  // R8: restart address is loaded by a flush
  a_r8_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr == $past(flush_addr));
  // R9: after an accepted request the pointer is even
  a_r9_align_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> fetch_addr[0] == 1'b0);
  // R10: a response only answers a request
  a_r10_resp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> pending);
endmodule

// File: rtl/pfq_byte_store.sv
`timescale 1ns/1ps
module pfq_byte_store
  import pfq_pkg::*;
#(
  parameter  int unsigned DEPTH = 6,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  split_t        sp,
  input  logic          rd_ready,
  output logic          out_valid,
  output byte_t         out_data,
  output logic [CW-1:0] level
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  byte_t         mem [DEPTH];
  logic [PW-1:0] rptr, wptr, wptr1;
  logic          empty, take, byp_take;
  logic [1:0]    st_n;
  byte_t         st0;
  logic [CW:0]   nxt;

  assign empty     = (level == '0);
  assign out_valid = !flush && (!empty || sp.n != 2'd0);
  assign out_data  = empty ? sp.b0 : mem[rptr];
  assign take      = out_valid && rd_ready;
  assign byp_take  = take && empty;
  assign st_n      = byp_take ? sp.n - 2'd1 : sp.n;
  assign st0       = byp_take ? sp.b1 : sp.b0;
  assign wptr1     = step(wptr);
  assign nxt       = {1'b0, level} + {{(CW-1){1'b0}}, sp.n} - {{CW{1'b0}}, take};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      level <= '0;
      rptr  <= '0;
      wptr  <= '0;
    end else begin
      level <= nxt[CW-1:0];
      if (take && !empty) rptr <= step(rptr);
      case (st_n)
        2'd1:    wptr <= wptr1;
        2'd2:    wptr <= step(wptr1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (st_n != 2'd0 && PW'(i) == wptr)      mem[i] <= st0;
      else if (st_n == 2'd2 && PW'(i) == wptr1) mem[i] <= sp.b1;
    end
  end

  // R1: level bounded by the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R1: incoming bytes always fit
  a_r1_room: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> nxt <= (CW+1)'(DEPTH));
  // R6: a stalled byte holds
  a_r6_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !rd_ready && !flush |=> flush || (out_valid && $stable(out_data)));
  // R8: a flush empties the store
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);
  // R7: one in and one out leaves the level unchanged
  a_r7_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && take && sp.n == 2'd1 |=> level == $past(level));
endmodule

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int unsigned   DEPTH      = 6,
  parameter int unsigned   AW         = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr,
  input  logic          resp_valid,
  input  logic [15:0]   resp_data,
  output logic          byte_valid,
  input  logic          byte_ready,
  output logic [7:0]    byte_data
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          space_ok;
  logic          keep, keep_odd;
  split_t        sp;
  logic [CW-1:0] level;

  assign space_ok = (level <= CW'(DEPTH - 2));

  pfq_fetch_ctrl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .space_ok(space_ok), .fetch_ready(fetch_ready), .resp_valid(resp_valid),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .keep(keep), .keep_odd(keep_odd)
  );

  pfq_word_split u_split (
    .keep(keep), .odd(keep_odd), .word(resp_data), .sp(sp)
  );

  pfq_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .sp(sp), .rd_ready(byte_ready),
    .out_valid(byte_valid), .out_data(byte_data), .level(level)
  );

  // R2: a request is raised only with two free slots
  a_r2_room_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> level <= CW'(DEPTH - 2));
  // R8: nothing offered during a flush
  a_r8_quiet_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !byte_valid && !fetch_valid);
endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
  localparam int AW = 20;
  localparam int DEPTH = 6;
  localparam logic [AW-1:0] RST_A = 20'hFFFF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, fetch_ready = 1'b0, resp_valid = 1'b0, byte_ready = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic [15:0] resp_data = '0;
  logic fetch_valid, byte_valid;
  logic [AW-1:0] fetch_addr;
  logic [7:0] byte_data;

  prefetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(RST_A)) i_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic [AW-1:0] exp_next;
  string cur_tag = "R4";

  // controls set by the main sequence
  bit run = 0, flush_req = 0;
  logic [AW-1:0] flush_tgt = '0;
  int rdy_mode = 2, frdy_mode = 2, lat_mode = 4;

  // model state
  int occ = 0, cdown = 0, nb = 0, stale_seen = 0, both_seen = 0, byp_seen = 0;
  bit out_pend = 0, out_stale = 0, prev_hold = 0, prev_bstall = 0, prev_both = 0;
  bit drive_resp = 0, exp_fv = 0, exp_bv = 0, hs_b = 0;
  logic [AW-1:0] out_addr = '0, nfa = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h3, a[19:16]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected bytes in address order
  task automatic load_run(input logic [AW-1:0] a);
    exp_q.delete();
    exp_next = a;
  endtask

  task automatic refill();
    while (exp_q.size() < 32) begin
      exp_q.push_back(pat(exp_next));
      exp_next = exp_next + 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // bus model, consumer and monitor
  initial begin
    logic [AW-1:0] al;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (run) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        flush = flush_req;
        flush_addr = flush_tgt;
        flush_req = 0;
        drive_resp = out_pend && cdown == 0;
        al = {out_addr[AW-1:1], 1'b0};
        resp_valid = drive_resp;
        resp_data = drive_resp ? {pat(al + 1'b1), pat(al)} : 16'h0;
        fetch_ready = (frdy_mode == 2) ? lfsr[3] : frdy_mode[0];
        byte_ready = (rdy_mode == 2) ? (lfsr[5] | lfsr[7]) : rdy_mode[0];
        #1;
        nb = (drive_resp && !out_stale && !flush) ? (out_addr[0] ? 1 : 2) : 0;
        exp_fv = !flush && !out_pend && (DEPTH - occ) >= 2;
        check(fetch_valid == exp_fv, (prev_hold && !flush) ? "R3" : (prev_both ? "R7" : "R2"),
              "fetch_valid", fetch_valid, exp_fv);
        if (fetch_valid && exp_fv)
          check(fetch_addr == nfa, nfa[0] ? "R9" : "R8", "fetch_addr", fetch_addr, nfa);
        exp_bv = !flush && (occ > 0 || nb > 0);
        if (drive_resp && out_stale && occ == 0)
          check(byte_valid == exp_bv, "R10", "byte_valid on dropped word", byte_valid, exp_bv);
        else if (occ == 0 && nb > 0) begin
          check(byte_valid == exp_bv, "R5", "byte_valid bypass", byte_valid, exp_bv);
          byp_seen++;
        end else if (flush)
          check(byte_valid == exp_bv, "R8", "byte_valid in flush", byte_valid, exp_bv);
        else
          check(byte_valid == exp_bv, prev_bstall ? "R6" : "R1", "byte_valid", byte_valid, exp_bv);
        // monitor: pop and compare
        hs_b = byte_valid && byte_ready;
        if (hs_b) begin
          refill();
          got = exp_q.pop_front();
          check(byte_data == got, (occ == 0) ? "R5" : cur_tag, "byte_data", byte_data, got);
        end
        // model update
        prev_hold = fetch_valid && !fetch_ready;
        prev_bstall = byte_valid && !byte_ready;
        prev_both = (nb > 0) && hs_b;
        if (prev_both) both_seen++;
        if (drive_resp) begin
          if (out_stale || flush) stale_seen++;
          out_pend = 0;
        end else if (out_pend) cdown--;
        if (flush) begin
          occ = 0;
          if (out_pend) out_stale = 1;
          nfa = flush_addr;
          load_run(flush_addr);
        end else occ = occ + nb - (hs_b ? 1 : 0);
        if (fetch_valid && fetch_ready) begin
          out_pend = 1;
          out_stale = 0;
          out_addr = fetch_addr;
          cdown = (lat_mode < 4) ? lat_mode : int'(lfsr[9:8]);
          nfa = {fetch_addr[AW-1:1] + 1'b1, 1'b0};
        end
        refill();
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(byte_valid == 1'b0, "R11", "byte_valid after reset", byte_valid, 0);
    check(fetch_valid == 1'b1, "R11", "fetch_valid after reset", fetch_valid, 1);
    check(fetch_addr == RST_A, "R11", "fetch_addr after reset", fetch_addr, RST_A);
    nfa = RST_A;
    load_run(RST_A);
    refill();
    run = 1;

    // streaming with random stalls on both sides (R4, R6, R7)
    cur_tag = "R4";
    repeat (3000) @(posedge clk);

    // consumer stalled: queue fills (R1)
    rdy_mode = 0; frdy_mode = 1; lat_mode = 0;
    repeat (40) @(posedge clk);
    @(negedge clk); #2;
    check(byte_valid == 1'b1, "R1", "byte_valid when full", byte_valid, 1);
    check(fetch_valid == 1'b0, "R1", "fetch_valid when full", fetch_valid, 0);

    // flushes to even and odd targets, with words in flight (R8, R9, R10)
    rdy_mode = 2; frdy_mode = 2;
    for (int i = 0; i < 60; i++) begin
      lat_mode = (i % 3 == 0) ? 3 : 4;
      @(posedge clk);
      flush_tgt = 20'h12340 + 20'(i * 37);
      cur_tag = flush_tgt[0] ? "R9" : "R8";
      flush_req = 1;
      repeat (2 + (i % 9) * 3) @(posedge clk);
    end

    // fast consumer after flushes exercises the bypass (R5)
    rdy_mode = 1; frdy_mode = 1; lat_mode = 2; cur_tag = "R5";
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      flush_tgt = 20'h00400 + 20'(i * 3);
      flush_req = 1;
      repeat (20) @(posedge clk);
    end
    repeat (10) @(posedge clk);
    run = 0;
    check(stale_seen > 0, "R10", "dropped responses seen", stale_seen, 1);
    check(both_seen > 0, "R7", "simultaneous write and read seen", both_seen, 1);
    check(byp_seen > 0, "R5", "bypass cycles seen", byp_seen, 1);
    finish_run();
  end
endmodule